// File: doc/BRIEF.md
# Multi-width FIFO data access port

This block is the host-side data window of one serial channel. A 32-bit memory-mapped bus writes transmit bytes into a 64-entry transmit FIFO and reads receive bytes out of a 64-entry receive FIFO. One bus access can move one, two, three or four bytes, and the FIFO pointer moves by exactly the number of bytes moved. Bytes are handled in lane order: the lowest enabled byte lane holds the oldest byte.

A second read-only window returns each received byte together with the line-status byte stored beside it. This window accepts only 16-bit or 32-bit reads, so a data byte is never separated from its status. On the line side, a push port stores one receive entry (data plus status) per clock, and a pop port removes one transmit byte per clock. Reads that ask for more bytes than are stored, writes that bring more bytes than fit, and badly sized status reads each set their own sticky flag. The flags clear only on reset.

Top module: `fifo_data_port`

## Requirements
- R1: After reset both FIFOs are empty (`tx_valid_o`=0, `rx_full_o`=0) and `underflow_o`, `overflow_o` and `access_err_o` are 0.
- R2: A bus write to the data window (byte addresses 0x100 to 0x13F) with 1 to 4 contiguous byte enables stores the enabled bytes into the transmit FIFO. The lowest lane is stored first. The line side pops them in that order, one per clock, and the head byte appears on `tx_data_o` while `tx_valid_o` is 1.
- R3: A bus read of the data window with N enabled lanes pops the N oldest receive bytes. Lanes are filled in order from the lowest enabled lane upward (lane k is `bus_rdata_o[8k+7:8k]`). Disabled lanes read 0.
- R4: Each FIFO holds 64 bytes. `rx_full_o` is 1 exactly when 64 receive entries are stored. A line push while the receive FIFO is full is discarded. The transmit FIFO accepts exactly 64 bytes.
- R5: A data-window read or a status-window read that requests more than is stored pops only what is stored, places it in the lowest requested lanes or pairs, returns 0 elsewhere, and sets `underflow_o`.
- R6: A data-window write that supplies more bytes than there is free space stores bytes in lane order until the FIFO is full, discards the rest, and sets `overflow_o`.
- R7: A status-window read (0x180 to 0x1FF) with byte enables 4'b0011 or 4'b1100 pops one entry. That 16-bit half carries the data byte in its low byte and the status byte in its high byte. The other half reads 0.
- R8: A status-window read with byte enables 4'b1111 pops two entries. The older entry is in bits 15:0 and the newer entry is in bits 31:16.
- R9: A status-window read with any byte enable pattern other than 4'b0011, 4'b1100 or 4'b1111 pops nothing, returns 0 and sets `access_err_o`.
- R10: Accesses outside the two windows have no FIFO effect and read 0. Writes to the status window are ignored. Address bits 1:0 are ignored; lanes come from the byte enables.
- R11: A line push and a bus pop in the same cycle both take effect, and the pop sees only entries stored before that cycle. Likewise, a bus write and a line pop in the same cycle both take effect.
- R12: `underflow_o`, `overflow_o` and `access_err_o` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 9 | Byte address within the channel region |
| bus_be_i | input | 4 | Byte lane enables |
| bus_rd_i | input | 1 | Read strobe, one access per cycle |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_push_i | input | 1 | Line side stores one receive entry |
| rx_data_i | input | 8 | Received data byte |
| rx_stat_i | input | 8 | Line-status byte for that data byte |
| rx_full_o | output | 1 | Receive FIFO holds 64 entries |
| tx_pop_i | input | 1 | Line side removes the head transmit byte |
| tx_data_o | output | 8 | Head transmit byte |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| underflow_o | output | 1 | Sticky: a read asked for more than was stored |
| overflow_o | output | 1 | Sticky: a write brought more than would fit |
| access_err_o | output | 1 | Sticky: badly sized status-window read |

## Verification
A pointer that advances by the wrong amount shows up at the next read or pop. The first byte after the fault is out of order, and any later fill-level check is off. A wrong lane rank makes a byte appear in the wrong lane or as zero in the cycle of the read itself. A wrong fill count shows up at a 64-entry boundary: either `rx_full_o` flips at the wrong point, or a byte that should have been discarded reappears after the FIFO drains. The bench sweeps every start lane and width in both directions and fills both FIFOs to the limit, so each of these faults surfaces within a few bus accesses of the fault.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef struct packed {
    logic [7:0] stat;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_STAT = 2'd2
  } win_e;
endpackage

// File: rtl/fdp_rx_fifo.sv
module fdp_rx_fifo
  import fdp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  rx_entry_t             push_entry_i,
  input  logic [NW-1:0]         pop_n_i,
  output rx_entry_t [LANES-1:0] peek_o,
  output logic [CW-1:0]         cnt_o
);
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok;

  assign push_ok = push_i && (cnt != CW'(DEPTH));
  assign cnt_o   = cnt;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_ok);
      rd_ptr <= rd_ptr + AW'(pop_n_i);
      cnt    <= cnt + CW'(push_ok) - CW'(pop_n_i);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek_o[k] = mem[rd_ptr + AW'(k)];
  end

  assert_rx_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  assert_rx_pop_avail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_n_i) <= cnt);
endmodule

// File: rtl/fdp_tx_fifo.sv
module fdp_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NW-1:0]         push_n_i,
  input  logic [LANES-1:0][7:0] push_data_i,
  input  logic                  pop_i,
  output logic [7:0]            head_o,
  output logic                  valid_o,
  output logic [CW-1:0]         free_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          pop_ok;

  assign valid_o = cnt != '0;
  assign pop_ok  = pop_i && valid_o;
  assign head_o  = mem[rd_ptr];
  assign free_o  = CW'(DEPTH) - cnt;

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < LANES; j++) begin
      if (NW'(j) < push_n_i) mem[wr_ptr + AW'(j)] <= push_data_i[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n_i);
      rd_ptr <= rd_ptr + AW'(pop_ok);
      cnt    <= cnt + CW'(push_n_i) - CW'(pop_ok);
    end
  end

  assert_tx_push_fits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(push_n_i) <= free_o);
  assert_tx_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/fdp_lane_map.sv
module fdp_lane_map
  import fdp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 7,
  localparam int NW    = $clog2(LANES + 1),
  localparam int PAIRS = LANES / 2
) (
  input  win_e                  win_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [LANES-1:0]      be_i,
  input  logic [8*LANES-1:0]    wdata_i,
  input  rx_entry_t [LANES-1:0] rx_peek_i,
  input  logic [CW-1:0]         rx_cnt_i,
  input  logic [CW-1:0]         tx_free_i,
  output logic [8*LANES-1:0]    rdata_o,
  output logic [NW-1:0]         rx_pop_n_o,
  output logic [NW-1:0]         tx_push_n_o,
  output logic [LANES-1:0][7:0] tx_push_data_o,
  output logic                  set_uf_o,
  output logic                  set_of_o,
  output logic                  set_ae_o
);
  logic [LANES-1:0][NW-1:0] rank;
  logic [PAIRS-1:0][NW-1:0] prank;
  logic [NW-1:0]            req, preq, rx_avail, tx_room;
  logic                     pairs_ok, stat_ok;

  // rank of each enabled lane / pair among the enabled ones
  always_comb begin
    req = '0;
    for (int k = 0; k < LANES; k++) begin
      rank[k] = req;
      if (be_i[k]) req = req + 1'b1;
    end
    preq     = '0;
    pairs_ok = 1'b1;
    for (int p = 0; p < PAIRS; p++) begin
      prank[p] = preq;
      if (be_i[2*p] != be_i[2*p+1]) pairs_ok = 1'b0;
      if (be_i[2*p]) preq = preq + 1'b1;
    end
    stat_ok = pairs_ok && (preq == NW'(1) || preq == NW'(PAIRS));
  end

  assign rx_avail = (rx_cnt_i  >= CW'(LANES)) ? NW'(LANES) : NW'(rx_cnt_i);
  assign tx_room  = (tx_free_i >= CW'(LANES)) ? NW'(LANES) : NW'(tx_free_i);

  always_comb begin
    rdata_o    = '0;
    rx_pop_n_o = '0;
    set_uf_o   = 1'b0;
    set_ae_o   = 1'b0;
    if (rd_i && win_i == WIN_DATA) begin
      for (int k = 0; k < LANES; k++) begin
        for (int j = 0; j < LANES; j++) begin
          if (be_i[k] && rank[k] == NW'(j) && NW'(j) < rx_avail)
            rdata_o[8*k +: 8] = rx_peek_i[j].data;
        end
      end
      rx_pop_n_o = (req < rx_avail) ? req : rx_avail;
      set_uf_o   = req > rx_avail;
    end else if (rd_i && win_i == WIN_STAT) begin
      if (!stat_ok) begin
        set_ae_o = 1'b1;
      end else begin
        for (int p = 0; p < PAIRS; p++) begin
          for (int j = 0; j < PAIRS; j++) begin
            if (be_i[2*p] && prank[p] == NW'(j) && NW'(j) < rx_avail)
              rdata_o[16*p +: 16] = rx_peek_i[j];
          end
        end
        rx_pop_n_o = (preq < rx_avail) ? preq : rx_avail;
        set_uf_o   = preq > rx_avail;
      end
    end
  end

  always_comb begin
    tx_push_n_o    = '0;
    tx_push_data_o = '0;
    set_of_o       = 1'b0;
    if (wr_i && win_i == WIN_DATA) begin
      for (int k = 0; k < LANES; k++) begin
        for (int j = 0; j < LANES; j++) begin
          if (be_i[k] && rank[k] == NW'(j)) tx_push_data_o[j] = wdata_i[8*k +: 8];
        end
      end
      tx_push_n_o = (req < tx_room) ? req : tx_room;
      set_of_o    = req > tx_room;
    end
  end
endmodule

// File: rtl/fifo_data_port.sv
module fifo_data_port
  import fdp_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 9,
  parameter int DATA_BASE = 'h100,
  parameter int DATA_SPAN = 64,
  parameter int STAT_BASE = 'h180,
  parameter int STAT_SPAN = 128,
  localparam int LANES = BUS_W / 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NW    = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [LANES-1:0]  bus_be_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  input  logic [7:0]        rx_stat_i,
  output logic              rx_full_o,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              underflow_o,
  output logic              overflow_o,
  output logic              access_err_o
);
  win_e                  win;
  rx_entry_t             push_entry;
  rx_entry_t [LANES-1:0] rx_peek;
  logic [CW-1:0]         rx_cnt, tx_free;
  logic [NW-1:0]         rx_pop_n, tx_push_n;
  logic [LANES-1:0][7:0] tx_push_data;
  logic                  set_uf, set_of, set_ae;
  int                    addr_int;

  assign addr_int = int'(bus_addr_i);

  always_comb begin
    win = WIN_NONE;
    if (addr_int >= DATA_BASE && addr_int < DATA_BASE + DATA_SPAN) win = WIN_DATA;
    else if (addr_int >= STAT_BASE && addr_int < STAT_BASE + STAT_SPAN) win = WIN_STAT;
  end

  assign push_entry = '{stat: rx_stat_i, data: rx_data_i};
  assign rx_full_o  = rx_cnt == CW'(DEPTH);

  fdp_rx_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_push_i),
    .push_entry_i(push_entry),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .cnt_o       (rx_cnt)
  );

  fdp_tx_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_n_i   (tx_push_n),
    .push_data_i(tx_push_data),
    .pop_i      (tx_pop_i),
    .head_o     (tx_data_o),
    .valid_o    (tx_valid_o),
    .free_o     (tx_free)
  );

  fdp_lane_map #(.LANES(LANES), .CW(CW)) u_map (
    .win_i         (win),
    .rd_i          (bus_rd_i),
    .wr_i          (bus_wr_i),
    .be_i          (bus_be_i),
    .wdata_i       (bus_wdata_i),
    .rx_peek_i     (rx_peek),
    .rx_cnt_i      (rx_cnt),
    .tx_free_i     (tx_free),
    .rdata_o       (bus_rdata_o),
    .rx_pop_n_o    (rx_pop_n),
    .tx_push_n_o   (tx_push_n),
    .tx_push_data_o(tx_push_data),
    .set_uf_o      (set_uf),
    .set_of_o      (set_of),
    .set_ae_o      (set_ae)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      underflow_o  <= 1'b0;
      overflow_o   <= 1'b0;
      access_err_o <= 1'b0;
    end else begin
      underflow_o  <= underflow_o  | set_uf;
      overflow_o   <= overflow_o   | set_of;
      access_err_o <= access_err_o | set_ae;
    end
  end

  assert_err_no_pop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ae |-> (rx_pop_n == '0 && bus_rdata_o == '0));
  assert_stat_wr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && win != WIN_DATA) |-> tx_push_n == '0);
  assert_outside_no_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win == WIN_NONE) |-> (rx_pop_n == '0 && bus_rdata_o == '0));
  assert_uf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(underflow_o));
  assert_of_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(overflow_o));
  assert_ae_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(access_err_o));
  assert_full_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && rx_pop_n == '0) |=> rx_full_o);
endmodule

// File: tb/fifo_data_port_tb.sv
module fifo_data_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic [3:0]  bus_be;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_push;
  logic [7:0]  rx_data, rx_stat;
  logic        rx_full;
  logic        tx_pop;
  logic [7:0]  tx_data;
  logic        tx_valid, underflow, overflow, access_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_data_port u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_be_i(bus_be), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_stat_i(rx_stat), .rx_full_o(rx_full),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .underflow_o(underflow), .overflow_o(overflow), .access_err_o(access_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns read data sampled before the next posedge
  task automatic bus_op(input logic rd, input logic wr, input logic [8:0] a,
                        input logic [3:0] be, input logic [31:0] wd, output logic [31:0] rv);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    #1 rv = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic line_push(input logic [7:0] d, input logic [7:0] s);
    rx_push = 1'b1; rx_data = d; rx_stat = s;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic line_pop(output logic [7:0] d, output logic v);
    #1 d = tx_data; v = tx_valid;
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv, exp;
    logic [7:0]  d;
    logic        v;
    rst_n = 1'b0; bus_addr = '0; bus_be = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; rx_push = 1'b0; rx_data = '0; rx_stat = '0; tx_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 flags", {rx_full, tx_valid, underflow, overflow, access_err}, '0);

    // R2 transmit sweep over start lane and width
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 4 - s; n++) begin
        logic [31:0] wd;
        for (int k = 0; k < 4; k++) wd[8*k +: 8] = 8'(s*40 + n*10 + k);
        bus_op(1'b0, 1'b1, 9'(9'h100 + 4*s), 4'(((1 << n) - 1) << s), wd, rv);
        for (int i = 0; i < n; i++) begin
          line_pop(d, v);
          chk("R2 tx byte", {23'd0, v, d}, {23'd0, 1'b1, 8'(s*40 + n*10 + s + i)});
        end
        #1 chk("R2 tx drained", {31'd0, tx_valid}, 32'd0);
      end
    end

    // R3 receive sweep over start lane and width
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 4 - s; n++) begin
        for (int i = 0; i < n; i++) line_push(8'(s*50 + n*7 + i), 8'(i + 1));
        exp = '0;
        for (int i = 0; i < n; i++) exp[8*(s+i) +: 8] = 8'(s*50 + n*7 + i);
        bus_op(1'b1, 1'b0, 9'(9'h13C - 4*s), 4'(((1 << n) - 1) << s), '0, rv);
        chk("R3 rx lanes", rv, exp);
      end
    end
    chk("R3 no underflow", {31'd0, underflow}, 32'd0);

    // R7 status window 16-bit halves
    line_push(8'hA1, 8'h51);
    line_push(8'hA2, 8'h52);
    bus_op(1'b1, 1'b0, 9'h180, 4'b0011, '0, rv);
    chk("R7 low half", rv, 32'h0000_51A1);
    bus_op(1'b1, 1'b0, 9'h1A2, 4'b1100, '0, rv);
    chk("R7 high half", rv, 32'h52A2_0000);

    // R8 status window 32-bit
    line_push(8'hB1, 8'h61);
    line_push(8'hB2, 8'h62);
    bus_op(1'b1, 1'b0, 9'h1FC, 4'b1111, '0, rv);
    chk("R8 two pairs", rv, 32'h62B2_61B1);

    // R9 badly sized status reads
    line_push(8'hC1, 8'h71);
    bus_op(1'b1, 1'b0, 9'h180, 4'b0001, '0, rv);
    chk("R9 8-bit data", rv, 32'd0);
    chk("R9 flag", {31'd0, access_err}, 32'd1);
    bus_op(1'b1, 1'b0, 9'h184, 4'b0111, '0, rv);
    chk("R9 24-bit data", rv, 32'd0);
    bus_op(1'b1, 1'b0, 9'h100, 4'b0001, '0, rv);
    chk("R9 no pop", rv, 32'h0000_00C1);

    // R10 decode outside windows, status-window writes ignored
    line_push(8'hD1, 8'h81);
    bus_op(1'b1, 1'b0, 9'h140, 4'b1111, '0, rv);
    chk("R10 gap read", rv, 32'd0);
    bus_op(1'b1, 1'b0, 9'h000, 4'b1111, '0, rv);
    chk("R10 low read", rv, 32'd0);
    bus_op(1'b0, 1'b1, 9'h180, 4'b1111, 32'hDEAD_BEEF, rv);
    bus_op(1'b0, 1'b1, 9'h17C, 4'b1111, 32'hDEAD_BEEF, rv);
    #1 chk("R10 no tx push", {31'd0, tx_valid}, 32'd0);
    bus_op(1'b1, 1'b0, 9'h103, 4'b0001, '0, rv);
    chk("R10 entry kept", rv, 32'h0000_00D1);
    chk("R10 no flags", {30'd0, underflow, overflow}, 32'd0);

    // R4 receive fill to 64, 65th discarded
    for (int i = 0; i < 65; i++) begin
      line_push(8'(i), ~8'(i));
      if (i == 62) chk("R4 not full at 63", {31'd0, rx_full}, 32'd0);
      if (i == 63) chk("R4 full at 64", {31'd0, rx_full}, 32'd1);
    end
    for (int w = 0; w < 16; w++) begin
      bus_op(1'b1, 1'b0, 9'h100, 4'b1111, '0, rv);
      chk("R4 rx drain", rv, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    end
    chk("R4 not full", {31'd0, rx_full}, 32'd0);
    chk("R4 no underflow yet", {31'd0, underflow}, 32'd0);

    // R5 underflow: 2 stored, 3 requested
    line_push(8'hE1, 8'h91);
    line_push(8'hE2, 8'h92);
    bus_op(1'b1, 1'b0, 9'h100, 4'b1110, '0, rv);
    chk("R5 partial data", rv, 32'h00E2_E100);
    chk("R5 flag", {31'd0, underflow}, 32'd1);
    bus_op(1'b1, 1'b0, 9'h100, 4'b0001, '0, rv);
    chk("R5 empty after", rv, 32'd0);
    line_push(8'hE3, 8'h93);
    bus_op(1'b1, 1'b0, 9'h1C0, 4'b1111, '0, rv);
    chk("R5 status underflow", rv, 32'h0000_93E3);

    // R6 transmit overflow: fill 62, then a 4-byte write
    for (int w = 0; w < 15; w++)
      bus_op(1'b0, 1'b1, 9'h100, 4'b1111, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, rv);
    bus_op(1'b0, 1'b1, 9'h100, 4'b0011, 32'h0000_3D3C, rv);
    chk("R6 no overflow at 62", {31'd0, overflow}, 32'd0);
    bus_op(1'b0, 1'b1, 9'h100, 4'b1111, 32'h4140_3F3E, rv);
    chk("R6 flag", {31'd0, overflow}, 32'd1);
    for (int i = 0; i < 64; i++) begin
      line_pop(d, v);
      chk("R4 R6 tx order", {23'd0, v, d}, {23'd0, 1'b1, 8'(i)});
    end
    #1 chk("R6 rest discarded", {31'd0, tx_valid}, 32'd0);

    // R11 same-cycle line push with bus pop
    line_push(8'hF1, 8'hA1);
    rx_push = 1'b1; rx_data = 8'hF2; rx_stat = 8'hA2;
    bus_op(1'b1, 1'b0, 9'h100, 4'b0001, '0, rv);
    rx_push = 1'b0;
    chk("R11 rx old first", rv, 32'h0000_00F1);
    bus_op(1'b1, 1'b0, 9'h100, 4'b0001, '0, rv);
    chk("R11 rx new kept", rv, 32'h0000_00F2);
    // R11 same-cycle bus write with line pop
    bus_op(1'b0, 1'b1, 9'h100, 4'b0001, 32'h0000_00C3, rv);
    tx_pop = 1'b1;
    bus_op(1'b0, 1'b1, 9'h100, 4'b0100, 32'h00C4_0000, rv);
    tx_pop = 1'b0;
    line_pop(d, v);
    chk("R11 tx new kept", {23'd0, v, d}, {23'd0, 1'b1, 8'hC4});
    #1 chk("R11 tx drained", {31'd0, tx_valid}, 32'd0);

    // R12 flags still set, then reset clears them (R1)
    chk("R12 sticky", {29'd0, underflow, overflow, access_err}, 32'd7);
    rst_n = 1'b0;
    #1 chk("R1 R12 cleared", {rx_full, tx_valid, underflow, overflow, access_err}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_op(1'b1, 1'b0, 9'h100, 4'b0001, '0, rv);
    chk("R1 rx empty after reset", rv, 32'd0);

    summary();
    $finish;
  end
endmodule